// File: doc/BRIEF.md
# Real-Time Clock Register File

This block is the register side of a calendar clock chip, as seen by an 8-bit host bus. The host first writes a register index into an address register, then reads or writes the selected register through a data strobe. The block keeps seconds, minutes, hours, day of week, date, month and a two-digit year. A one-pulse-per-second tick input advances these counters, with carries through the whole calendar, including month lengths and leap years.

Reads of the time fields come back in BCD or in plain binary, as one control bit selects. Writes to the time fields are decoded in the same format and load the counters. Four status and control registers return fixed or partly fixed values. One of them holds an update-ended flag that each tick sets and that a read of that register clears. Every other index is a plain byte of battery-style storage.

The time counters are held in binary. Format conversion happens only on the bus side, so the counting logic is the same in both formats.

Top module: `rtc_regfile`

## Requirements
- R1: A pulse on `sel_wr` loads the low 6 bits of `bus_wdata` into the address register. The upper two bits are ignored, so index 64+n selects the same register as n. A data write in the same cycle as `sel_wr` uses the old address.
- R2: The time fields sit at index 0 (seconds), 2 (minutes), 4 (hours), 6 (day of week), 7 (date), 8 (month) and 9 (year 0..99). `bus_rdata` shows them in packed BCD (tens in bits 7:4, units in bits 3:0) when bit 2 of index 11 is 0, and in plain binary when that bit is 1.
- R3: A data write to a time-field index is decoded in the currently selected format and loads that counter. The new value is seen on the next read.
- R4: Each cycle with `tick_1hz` high advances the seconds. Seconds wrap 59→0 and carry into minutes. Minutes wrap 59→0 and carry into hours. Hours wrap 23→0 and carry into date and day of week. Without a tick or a write, the counters hold.
- R5: Day of week counts 1..7 and steps from 7 back to 1 at each midnight carry.
- R6: The date rolls over after the last day of the month: 31 days for months 1, 3, 5, 7, 8, 10 and 12; 30 days for months 4, 6, 9 and 11; 29 days for month 2 when year mod 4 is 0, and 28 otherwise. At rollover the date returns to 1 and the month advances. Month wraps 12→1 and carries into the year, and year wraps 99→0.
- R7: Index 10 reads 0x20 OR the low nibble last written to it (0x20 after reset).
- R8: Index 11 keeps only bit 2 of a write. It reads back that bit, with bit 1 always 1 (24-hour mode) and all other bits 0, so it reads 0x02 after reset.
- R9: Index 12 reads 0x10 while the update-ended flag is set and 0x00 otherwise. Every tick sets the flag. Writes to index 12 do not change what it reads.
- R10: A `dat_rd` pulse with index 12 selected clears the flag from the next cycle on. A tick in the same cycle wins, and the flag stays set.
- R11: Index 13 always reads 0x80, and writes to it have no effect.
- R12: Indexes 1, 3, 5 and 14..63 are plain read/write bytes that return the last value written.
- R13: After reset the time reads 00:00:00, day of week 1, date 1, month 1, year 0. The format is BCD, the address register is 0 and the flag is clear.
- R14: When a time-field write and a tick fall in the same cycle, the written field takes the written value. All other fields advance as the tick applied to the previous time dictates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| sel_wr | input | 1 | Load address register from `bus_wdata` |
| dat_wr | input | 1 | Write `bus_wdata` to the selected register |
| dat_rd | input | 1 | Read strobe for the selected register (clears flag at index 12) |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Contents of the selected register, combinational from the address register |

## Verification
A wrong counter value appears on `bus_rdata` on the first read of that field after the tick or write that caused it. A carry bug hides until the run crosses the matching boundary, so month ends, leap Februaries and the end of a century are driven directly. A bad format decode shows as a wrong value read back in the same cycle, because the conversion sits on the read path. A flag fault shows at index 12 either on the read after a tick or on the second of two back-to-back reads.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int RTC_AW = 6;
    localparam int RTC_DW = 8;
    localparam int RTC_DEPTH = 1 << RTC_AW;

    typedef logic [RTC_AW-1:0] rtc_idx_t;
    typedef logic [RTC_DW-1:0] rtc_byte_t;

    localparam rtc_idx_t IX_SEC   = rtc_idx_t'(0);
    localparam rtc_idx_t IX_MIN   = rtc_idx_t'(2);
    localparam rtc_idx_t IX_HOUR  = rtc_idx_t'(4);
    localparam rtc_idx_t IX_DOW   = rtc_idx_t'(6);
    localparam rtc_idx_t IX_DATE  = rtc_idx_t'(7);
    localparam rtc_idx_t IX_MON   = rtc_idx_t'(8);
    localparam rtc_idx_t IX_YEAR  = rtc_idx_t'(9);
    localparam rtc_idx_t IX_CTLA  = rtc_idx_t'(10);
    localparam rtc_idx_t IX_CTLB  = rtc_idx_t'(11);
    localparam rtc_idx_t IX_STAT  = rtc_idx_t'(12);
    localparam rtc_idx_t IX_VALID = rtc_idx_t'(13);

    typedef enum logic [2:0] {
        FLD_NONE, FLD_SEC, FLD_MIN, FLD_HOUR, FLD_DOW, FLD_DATE, FLD_MON, FLD_YEAR
    } rtc_field_e;

    typedef struct packed {
        rtc_byte_t sec;
        rtc_byte_t min;
        rtc_byte_t hour;
        rtc_byte_t dow;
        rtc_byte_t date;
        rtc_byte_t mon;
        rtc_byte_t year;
    } rtc_time_t;

    localparam rtc_time_t RTC_TIME_RESET = '{sec: 8'd0, min: 8'd0, hour: 8'd0,
                                             dow: 8'd1, date: 8'd1, mon: 8'd1, year: 8'd0};

    function automatic rtc_field_e idx_to_field(input rtc_idx_t ix);
        case (ix)
            IX_SEC:  return FLD_SEC;
            IX_MIN:  return FLD_MIN;
            IX_HOUR: return FLD_HOUR;
            IX_DOW:  return FLD_DOW;
            IX_DATE: return FLD_DATE;
            IX_MON:  return FLD_MON;
            IX_YEAR: return FLD_YEAR;
            default: return FLD_NONE;
        endcase
    endfunction

    function automatic rtc_byte_t field_value(input rtc_time_t t, input rtc_field_e f);
        case (f)
            FLD_SEC:  return t.sec;
            FLD_MIN:  return t.min;
            FLD_HOUR: return t.hour;
            FLD_DOW:  return t.dow;
            FLD_DATE: return t.date;
            FLD_MON:  return t.mon;
            FLD_YEAR: return t.year;
            default:  return '0;
        endcase
    endfunction

    function automatic rtc_byte_t to_bcd(input rtc_byte_t v);
        rtc_byte_t tens;
        rtc_byte_t ones;
        tens = v / 8'd10;
        ones = v % 8'd10;
        return {tens[3:0], ones[3:0]};
    endfunction

    function automatic rtc_byte_t from_bcd(input rtc_byte_t v);
        return (8'(v[7:4]) * 8'd10) + 8'(v[3:0]);
    endfunction

    function automatic rtc_byte_t month_len(input rtc_byte_t mon, input rtc_byte_t year);
        case (mon)
            8'd2:                      return (year[1:0] == 2'b00) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:   return 8'd30;
            default:                   return 8'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_nvram.sv
module rtc_nvram #(
    parameter int AW = 6,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/rtc_uf_latch.sv
module rtc_uf_latch (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst)        flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end

    // R9: a tick always leaves the flag set
    p_flag_set_r9: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_o);

    // R10: read without a concurrent tick clears the flag
    p_flag_clr_r10: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !flag_o);

    p_flag_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!set_i && !clr_i) |=> $stable(flag_o));

endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       ld_en,
    input  rtc_field_e ld_field,
    input  rtc_byte_t  ld_val,
    output rtc_time_t  now
);
    rtc_time_t adv;
    rtc_time_t nxt;
    logic      c_min, c_hour, c_day, c_mon, c_year;

    // Tick advance with full calendar carry chain
    always_comb begin
        adv    = now;
        c_min  = 1'b0;
        c_hour = 1'b0;
        c_day  = 1'b0;
        c_mon  = 1'b0;
        c_year = 1'b0;
        if (tick) begin
            if (now.sec >= 8'd59) begin
                adv.sec = 8'd0;
                c_min   = 1'b1;
            end else begin
                adv.sec = now.sec + 8'd1;
            end
        end
        if (c_min) begin
            if (now.min >= 8'd59) begin
                adv.min = 8'd0;
                c_hour  = 1'b1;
            end else begin
                adv.min = now.min + 8'd1;
            end
        end
        if (c_hour) begin
            if (now.hour >= 8'd23) begin
                adv.hour = 8'd0;
                c_day    = 1'b1;
            end else begin
                adv.hour = now.hour + 8'd1;
            end
        end
        if (c_day) begin
            adv.dow = (now.dow >= 8'd7) ? 8'd1 : now.dow + 8'd1;
            if (now.date >= month_len(now.mon, now.year)) begin
                adv.date = 8'd1;
                c_mon    = 1'b1;
            end else begin
                adv.date = now.date + 8'd1;
            end
        end
        if (c_mon) begin
            if (now.mon >= 8'd12) begin
                adv.mon = 8'd1;
                c_year  = 1'b1;
            end else begin
                adv.mon = now.mon + 8'd1;
            end
        end
        if (c_year) begin
            adv.year = (now.year >= 8'd99) ? 8'd0 : now.year + 8'd1;
        end
    end

    // Host load overrides only the addressed field
    always_comb begin
        nxt = adv;
        if (ld_en) begin
            case (ld_field)
                FLD_SEC:  nxt.sec  = ld_val;
                FLD_MIN:  nxt.min  = ld_val;
                FLD_HOUR: nxt.hour = ld_val;
                FLD_DOW:  nxt.dow  = ld_val;
                FLD_DATE: nxt.date = ld_val;
                FLD_MON:  nxt.mon  = ld_val;
                FLD_YEAR: nxt.year = ld_val;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) now <= RTC_TIME_RESET;
        else     now <= nxt;
    end

    // R4: seconds wrap and carry into minutes
    p_sec_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (tick && !ld_en && now.sec == 8'd59 && now.min < 8'd59)
        |=> (now.sec == 8'd0 && now.min == 8'($past(now.min) + 8'd1)));

    // R4: counters hold with no tick and no load
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!tick && !ld_en) |=> $stable(now));

    // R5: day of week wraps 7 -> 1 at midnight
    p_dow_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && !ld_en && now.sec == 8'd59 && now.min == 8'd59
         && now.hour == 8'd23 && now.dow == 8'd7) |=> (now.dow == 8'd1));

    // R6: leap-year February reaches day 29
    p_leap_r6: assert property (@(posedge clk) disable iff (rst)
        (tick && !ld_en && now.sec == 8'd59 && now.min == 8'd59 && now.hour == 8'd23
         && now.mon == 8'd2 && now.date == 8'd28 && now.year[1:0] == 2'b00)
        |=> (now.date == 8'd29 && now.mon == 8'd2));

endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_1hz,
    input  logic       sel_wr,
    input  logic       dat_wr,
    input  logic       dat_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata
);
    rtc_idx_t   addr_q;
    logic [3:0] ctla_q;
    logic       bin_mode_q;
    logic       uf_flag;
    rtc_field_e sel_field;
    rtc_time_t  now;
    rtc_byte_t  ld_val;
    rtc_byte_t  ram_rd;
    rtc_byte_t  fld_raw;
    logic       is_special;
    logic       ram_we;
    logic       ld_en;

    assign sel_field  = idx_to_field(addr_q);
    assign is_special = (sel_field != FLD_NONE) || (addr_q == IX_CTLA) || (addr_q == IX_CTLB)
                        || (addr_q == IX_STAT) || (addr_q == IX_VALID);
    assign ram_we     = dat_wr && !is_special;
    assign ld_en      = dat_wr && (sel_field != FLD_NONE);
    assign ld_val     = bin_mode_q ? bus_wdata : from_bcd(bus_wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q     <= '0;
            ctla_q     <= '0;
            bin_mode_q <= 1'b0;
        end else begin
            if (sel_wr) addr_q <= bus_wdata[RTC_AW-1:0];
            if (dat_wr && addr_q == IX_CTLA) ctla_q <= bus_wdata[3:0];
            if (dat_wr && addr_q == IX_CTLB) bin_mode_q <= bus_wdata[2];
        end
    end

    rtc_time_core u_core (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_1hz),
        .ld_en    (ld_en),
        .ld_field (sel_field),
        .ld_val   (ld_val),
        .now      (now)
    );

    rtc_uf_latch u_uf (
        .clk    (clk),
        .rst    (rst),
        .set_i  (tick_1hz),
        .clr_i  (dat_rd && addr_q == IX_STAT),
        .flag_o (uf_flag)
    );

    rtc_nvram #(.AW(RTC_AW), .DW(RTC_DW)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (addr_q),
        .wdata (bus_wdata),
        .raddr (addr_q),
        .rdata (ram_rd)
    );

    assign fld_raw = field_value(now, sel_field);

    always_comb begin
        if (sel_field != FLD_NONE) begin
            bus_rdata = bin_mode_q ? fld_raw : to_bcd(fld_raw);
        end else begin
            case (addr_q)
                IX_CTLA:  bus_rdata = {4'h2, ctla_q};
                IX_CTLB:  bus_rdata = {5'b0, bin_mode_q, 2'b10};
                IX_STAT:  bus_rdata = {3'b0, uf_flag, 4'b0};
                IX_VALID: bus_rdata = 8'h80;
                default:  bus_rdata = ram_rd;
            endcase
        end
    end

    // R11: validity register is constant
    p_valid_const_r11: assert property (@(posedge clk) disable iff (rst)
        (addr_q == IX_VALID) |-> (bus_rdata == 8'h80));

    // R8: 24-hour bit always reads set, unused bits zero
    p_ctlb_shape_r8: assert property (@(posedge clk) disable iff (rst)
        (addr_q == IX_CTLB) |-> (bus_rdata[1] && bus_rdata[7:3] == 5'b0 && !bus_rdata[0]));

    // R12: storage byte returns the last write
    p_ram_rw_r12: assert property (@(posedge clk) disable iff (rst)
        (dat_wr && !sel_wr && !is_special) |=> (bus_rdata == $past(bus_wdata)));

endmodule

// File: tb/rtc_regfile_tb.sv
module rtc_regfile_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_1hz = 1'b0;
    logic       sel_wr = 1'b0;
    logic       dat_wr = 1'b0;
    logic       dat_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    int m_sec, m_min, m_hr, m_dow, m_date, m_mon, m_yr;
    bit m_bin, m_flag;
    logic [7:0] m_ram [64];
    bit m_ram_ok [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_regfile u_dut (
        .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .sel_wr(sel_wr),
        .dat_wr(dat_wr), .dat_rd(dat_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic int days_of(int mo, int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] enc(int v);
        if (m_bin) return 8'(v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    task automatic check(string req, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    task automatic m_tick();
        m_flag = 1'b1;
        m_sec++;
        if (m_sec < 60) return;
        m_sec = 0; m_min++;
        if (m_min < 60) return;
        m_min = 0; m_hr++;
        if (m_hr < 24) return;
        m_hr = 0;
        m_dow = (m_dow == 7) ? 1 : m_dow + 1;
        m_date++;
        if (m_date <= days_of(m_mon, m_yr)) return;
        m_date = 1; m_mon++;
        if (m_mon <= 12) return;
        m_mon = 1;
        m_yr = (m_yr + 1) % 100;
    endtask

    task automatic set_addr(logic [7:0] a);
        @(negedge clk); sel_wr = 1'b1; bus_wdata = a;
        @(negedge clk); sel_wr = 1'b0;
    endtask

    task automatic wr_reg(logic [7:0] a, logic [7:0] d);
        set_addr(a);
        dat_wr = 1'b1; bus_wdata = d;
        @(negedge clk); dat_wr = 1'b0;
    endtask

    task automatic rd_reg(logic [7:0] a, output logic [7:0] v);
        set_addr(a);
        v = bus_rdata;
        dat_rd = 1'b1;
        @(negedge clk); dat_rd = 1'b0;
        if (a[5:0] == 6'd12) m_flag = 1'b0;
    endtask

    task automatic do_tick();
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
        m_tick();
    endtask

    task automatic set_time(int s, int mi, int h, int dw, int d, int mo, int y);
        m_sec = s; m_min = mi; m_hr = h; m_dow = dw; m_date = d; m_mon = mo; m_yr = y;
        wr_reg(8'd0, enc(s)); wr_reg(8'd2, enc(mi)); wr_reg(8'd4, enc(h));
        wr_reg(8'd6, enc(dw)); wr_reg(8'd7, enc(d)); wr_reg(8'd8, enc(mo));
        wr_reg(8'd9, enc(y));
    endtask

    task automatic check_time(string req);
        logic [7:0] v;
        rd_reg(8'd0, v); check(req, v, enc(m_sec));
        rd_reg(8'd2, v); check(req, v, enc(m_min));
        rd_reg(8'd4, v); check(req, v, enc(m_hr));
        rd_reg(8'd6, v); check(req, v, enc(m_dow));
        rd_reg(8'd7, v); check(req, v, enc(m_date));
        rd_reg(8'd8, v); check(req, v, enc(m_mon));
        rd_reg(8'd9, v); check(req, v, enc(m_yr));
    endtask

    task automatic set_format(bit bin);
        logic [7:0] v;
        wr_reg(8'd11, bin ? 8'hFC : 8'hFB);
        m_bin = bin;
        rd_reg(8'd11, v);
        check("R8 format readback", v, bin ? 8'h06 : 8'h02);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd20240611));
        m_sec = 0; m_min = 0; m_hr = 0; m_dow = 1; m_date = 1; m_mon = 1; m_yr = 0;
        m_bin = 1'b0; m_flag = 1'b0;
        for (int i = 0; i < 64; i++) m_ram_ok[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R13 reset state; address 0 selects seconds
        @(negedge clk); check("R13 address reset", bus_rdata, 8'h00);
        check_time("R13 reset time");
        rd_reg(8'd10, v); check("R7 reset ctla", v, 8'h20);
        rd_reg(8'd11, v); check("R8 reset ctlb", v, 8'h02);
        rd_reg(8'd12, v); check("R9 reset flag", v, 8'h00);
        rd_reg(8'd13, v); check("R11 valid reg", v, 8'h80);

        // R7 low nibble kept, high forced
        wr_reg(8'd10, 8'hAB); rd_reg(8'd10, v); check("R7 ctla nibble", v, 8'h2B);
        // R11 writes ignored, R1 alias 77 -> 13
        wr_reg(8'd13, 8'h00); rd_reg(8'h4D, v); check("R11 R1 alias write-ignore", v, 8'h80);
        // R1 alias on a storage byte: 0x54 -> 20
        wr_reg(8'h54, 8'h3C); rd_reg(8'd20, v); check("R1 alias storage", v, 8'h3C);
        m_ram[20] = 8'h3C; m_ram_ok[20] = 1'b1;

        // R3 R4 R5 R6 century rollover in BCD
        set_time(59, 59, 23, 7, 31, 12, 99);
        check_time("R3 BCD load");
        do_tick(); check_time("R6 R5 year wrap");
        // R9 flag set by tick, R10 cleared by read
        rd_reg(8'd12, v); check("R9 flag set", v, 8'h10);
        rd_reg(8'd12, v); check("R10 flag cleared", v, 8'h00);
        // R9 write to status has no effect
        wr_reg(8'd12, 8'hFF); rd_reg(8'd12, v); check("R9 status write ignored", v, 8'h00);

        // R6 leap and non-leap February, 30-day month
        set_time(59, 59, 23, 3, 28, 2, 24); do_tick(); check_time("R6 leap day 29");
        set_time(59, 59, 23, 3, 29, 2, 24); do_tick(); check_time("R6 leap to March");
        set_time(59, 59, 23, 3, 28, 2, 23); do_tick(); check_time("R6 non-leap to March");
        set_time(59, 59, 23, 2, 30, 4, 50); do_tick(); check_time("R6 30-day month");

        // R2 binary format
        set_format(1'b1);
        set_time(59, 10, 5, 4, 17, 6, 42);
        check_time("R2 binary read");

        // R14 write and tick together: seconds written, minutes carry
        set_addr(8'd0);
        dat_wr = 1'b1; bus_wdata = enc(5); tick_1hz = 1'b1;
        @(negedge clk); dat_wr = 1'b0; tick_1hz = 1'b0;
        m_tick(); m_sec = 5;
        check_time("R14 collision");

        // R10 tick in same cycle as status read keeps flag
        rd_reg(8'd12, v);
        set_addr(8'd12);
        dat_rd = 1'b1; tick_1hz = 1'b1;
        @(negedge clk); dat_rd = 1'b0; tick_1hz = 1'b0;
        m_tick();
        rd_reg(8'd12, v); check("R10 set wins over clear", v, 8'h10);

        // Constrained random phase
        for (int it = 0; it < 80; it++) begin
            int op;
            op = int'($urandom % 4);
            if (op == 0) begin
                int r, ix;
                logic [7:0] d;
                r = int'($urandom % 53);
                ix = (r < 3) ? 1 + 2 * r : 14 + (r - 3);
                d = 8'($urandom);
                wr_reg(8'(ix), d); m_ram[ix] = d; m_ram_ok[ix] = 1'b1;
                r = int'($urandom % 53);
                ix = (r < 3) ? 1 + 2 * r : 14 + (r - 3);
                if (m_ram_ok[ix]) begin
                    rd_reg(8'(ix), v); check("R12 storage byte", v, m_ram[ix]);
                end
            end else if (op == 1) begin
                int s, mi, h, dw, d, mo, y;
                y = int'($urandom % 100); mo = 1 + int'($urandom % 12);
                d = 1 + int'($urandom % 31); if (d > days_of(mo, y)) d = days_of(mo, y);
                h = int'($urandom % 24); mi = int'($urandom % 60); s = int'($urandom % 60);
                dw = 1 + int'($urandom % 7);
                if ($urandom % 2 == 1) begin s = 59; mi = 59; h = 23; d = days_of(mo, y); end
                set_time(s, mi, h, dw, d, mo, y);
                check_time("R3 random load");
            end else if (op == 2) begin
                int n;
                n = 1 + int'($urandom % 3);
                for (int k = 0; k < n; k++) do_tick();
                check_time("R4 random advance");
                rd_reg(8'd12, v); check("R9 flag after ticks", v, 8'h10);
            end else begin
                set_format(($urandom % 2) == 1);
                check_time("R2 format switch");
            end
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule